// File: doc/BRIEF.md
# In-flight instruction token scoreboard

This block keeps the bookkeeping for every instruction that a simulated processor has in flight. A timing model first asks the block for a token, which is a small integer naming one slot in a per-instruction table. It then moves that instruction through its lifecycle by sending requests that carry the token. The block stores a phase code for each slot. The phase code also records whether the slot is occupied and whether a speculative store is pending. The block accepts a request only if it is legal in the token's current phase, and it returns an ok or error response one cycle later.

Instructions may be retired in any order. Commit or abort releases a token. A token that committed with a speculative store outstanding is released later, when its globally visible store arrives. The block does not decode instructions, produce results or hold memory data. It only enforces ordering and manages the token pool.

Top module: `insn_token_board`

## Requirements
- R1: While `rst` is high the block drives `req_ready` low and `resp_valid` low. After `rst` is released, every token is free and `req_ready` is high.
- R2: `req_op` encodings are: 0 allocate, 1 fetch, 2 decode, 3 execute, 4 memory read, 5 speculative store, 6 commit, 7 abort, 8 global store, and 9 to 15 unused. Each request accepted on a clock edge produces exactly one response with `resp_valid` high on the next edge. A cycle with no accepted request produces no response. For all opcodes other than allocate, `resp_tok` echoes `req_tok`.
- R3: Allocate with at least one free token answers ok with `resp_full` low. It returns the lowest-numbered free token in `resp_tok`, and that token becomes allocated.
- R4: Allocate with no free token answers `resp_ok`=0, `resp_full`=1 and `resp_tok`=0, and leaves the pool unchanged.
- R5: Fetch is legal only for a newly allocated token. Decode is legal only directly after fetch. Execute is legal only directly after decode.
- R6: Memory read is legal once, directly after execute. Speculative store is legal once, after execute or after memory read. Neither is mandatory.
- R7: Commit is legal after execute, memory read or speculative store. Without a pending speculative store, commit frees the token. With one, the token stays held, waiting for its global store.
- R8: Abort is legal in any allocated phase up to and including speculative store, and it frees the token. It is illegal for a committed token.
- R9: Global store is legal only for a token that committed with a pending speculative store. It then frees the token. At any other time it is an error.
- R10: Any request that is illegal in the token's phase, names a free token, or uses an unused opcode answers `resp_ok`=0, `resp_full`=0 and changes no state.
- R11: Tokens are independent. Any token may commit or abort while older tokens are still in flight, and the token it frees is reused by the next allocate if it is the lowest free one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 4 | Request opcode (see R2) |
| req_tok | input | TOK_W | Token the request refers to (ignored for allocate) |
| resp_valid | output | 1 | Response present, one cycle after an accepted request |
| resp_ok | output | 1 | Request was legal and performed |
| resp_full | output | 1 | Allocate refused because no token was free |
| resp_tok | output | TOK_W | Allocated token, or the echoed request token |

## Verification
The hardest states to reach are a token waiting in the committed-with-pending-store phase while the pool is nearly exhausted, and retirements that leave holes in the pool in arbitrary places. The bench covers both. Directed sequences fill all sixteen slots, retire middle tokens out of order, and park a token after commit with a pending store. A long seeded run follows; three quarters of its requests are the legal next step of a randomly chosen token, so many tokens sit in mixed phases at once. The remaining requests are illegal steps or unused opcodes. A behavioural model of the pool predicts every response, so a wrong lowest-free choice or a state change on a rejected request shows up in a later answer.

// File: rtl/tkb_pkg.sv
package tkb_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ALLOC     = 4'd0,
        OP_FETCH     = 4'd1,
        OP_DECODE    = 4'd2,
        OP_EXEC      = 4'd3,
        OP_LOAD      = 4'd4,
        OP_SPEC_ST   = 4'd5,
        OP_COMMIT    = 4'd6,
        OP_ABORT     = 4'd7,
        OP_GLOBAL_ST = 4'd8
    } op_e;

    // Phase code per slot; PH_FREE doubles as "not valid",
    // PH_STORED / PH_GWAIT carry the pending speculative store.
    typedef enum logic [2:0] {
        PH_FREE     = 3'd0,
        PH_ALLOC    = 3'd1,
        PH_FETCHED  = 3'd2,
        PH_DECODED  = 3'd3,
        PH_EXECUTED = 3'd4,
        PH_LOADED   = 3'd5,
        PH_STORED   = 3'd6,
        PH_GWAIT    = 3'd7
    } phase_e;

    typedef struct packed {
        logic   legal;
        phase_e next;
    } step_t;

    typedef struct packed {
        logic ok;
        logic full;
    } status_t;

    // Legality and successor phase for every opcode except allocate.
    function automatic step_t step_of(input op_e op, input phase_e cur);
        step_t s;
        s.legal = 1'b0;
        s.next  = cur;
        case (op)
            OP_FETCH:   if (cur == PH_ALLOC)    s = '{1'b1, PH_FETCHED};
            OP_DECODE:  if (cur == PH_FETCHED)  s = '{1'b1, PH_DECODED};
            OP_EXEC:    if (cur == PH_DECODED)  s = '{1'b1, PH_EXECUTED};
            OP_LOAD:    if (cur == PH_EXECUTED) s = '{1'b1, PH_LOADED};
            OP_SPEC_ST: if (cur == PH_EXECUTED || cur == PH_LOADED)
                            s = '{1'b1, PH_STORED};
            OP_COMMIT: begin
                if (cur == PH_EXECUTED || cur == PH_LOADED) s = '{1'b1, PH_FREE};
                else if (cur == PH_STORED)                   s = '{1'b1, PH_GWAIT};
            end
            OP_ABORT:   if (cur != PH_FREE && cur != PH_GWAIT)
                            s = '{1'b1, PH_FREE};
            OP_GLOBAL_ST: if (cur == PH_GWAIT)  s = '{1'b1, PH_FREE};
            default: ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/tkb_free_pick.sv
module tkb_free_pick #(
    parameter int NUM_TOK = 16,
    parameter int TOK_W   = 4
) (
    input  logic [NUM_TOK-1:0] busy,
    output logic               any_free,
    output logic [TOK_W-1:0]   pick
);
    // Scan from the top so the last hit is the lowest free index.
    always_comb begin
        any_free = 1'b0;
        pick     = '0;
        for (int i = NUM_TOK - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                any_free = 1'b1;
                pick     = TOK_W'(i);
            end
        end
    end
endmodule

// File: rtl/tkb_phase_table.sv
module tkb_phase_table
    import tkb_pkg::*;
#(
    parameter int NUM_TOK = 16,
    parameter int TOK_W   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [TOK_W-1:0]   wr_tok,
    input  phase_e             wr_phase,
    input  logic [TOK_W-1:0]   rd_tok,
    output phase_e             rd_phase,
    output logic               rd_in_range,
    output logic [NUM_TOK-1:0] busy
);
    localparam bool_full_range = (NUM_TOK == (1 << TOK_W));

    phase_e ph [NUM_TOK];

    for (genvar i = 0; i < NUM_TOK; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                ph[i] <= PH_FREE;
            else if (wr_en && wr_tok == TOK_W'(i))
                ph[i] <= wr_phase;
        end
        assign busy[i] = (ph[i] != PH_FREE);

        // R3: a free slot can only become newly allocated
        a_r3_free_to_alloc: assert property (@(posedge clk) disable iff (rst)
            (ph[i] == PH_FREE) |=> (ph[i] == PH_FREE || ph[i] == PH_ALLOC));
        // R5: an allocated slot moves on only to fetched (or aborts)
        a_r5_alloc_to_fetch: assert property (@(posedge clk) disable iff (rst)
            (ph[i] == PH_ALLOC) |=>
                (ph[i] == PH_ALLOC || ph[i] == PH_FETCHED || ph[i] == PH_FREE));
        // R9: a committed slot with a pending store is left only by freeing
        a_r9_gwait_exit: assert property (@(posedge clk) disable iff (rst)
            (ph[i] == PH_GWAIT) |=> (ph[i] == PH_GWAIT || ph[i] == PH_FREE));
    end

    if (bool_full_range) begin : g_full
        assign rd_in_range = 1'b1;
        assign rd_phase    = ph[rd_tok];
    end else begin : g_part
        assign rd_in_range = (32'(rd_tok) < 32'(NUM_TOK));
        assign rd_phase    = rd_in_range ? ph[rd_tok] : PH_FREE;
    end
endmodule

// File: rtl/tkb_step_decide.sv
module tkb_step_decide
    import tkb_pkg::*;
#(
    parameter int TOK_W = 4
) (
    input  logic [OP_W-1:0]  op_raw,
    input  logic [TOK_W-1:0] tok,
    input  phase_e           cur,
    input  logic             in_range,
    input  logic             any_free,
    input  logic [TOK_W-1:0] pick,
    output logic             wr_en,
    output logic [TOK_W-1:0] wr_tok,
    output phase_e           wr_phase,
    output status_t          status,
    output logic [TOK_W-1:0] out_tok
);
    op_e   op;
    step_t st;

    assign op = op_e'(op_raw);
    assign st = step_of(op, cur);

    always_comb begin
        wr_en    = 1'b0;
        wr_tok   = tok;
        wr_phase = cur;
        status   = '{ok: 1'b0, full: 1'b0};
        out_tok  = tok;
        if (op == OP_ALLOC) begin
            out_tok = any_free ? pick : '0;
            if (any_free) begin
                wr_en    = 1'b1;
                wr_tok   = pick;
                wr_phase = PH_ALLOC;
                status   = '{ok: 1'b1, full: 1'b0};
            end else begin
                status   = '{ok: 1'b0, full: 1'b1};
            end
        end else if (in_range && st.legal) begin
            wr_en    = 1'b1;
            wr_phase = st.next;
            status   = '{ok: 1'b1, full: 1'b0};
        end
    end
endmodule

// File: rtl/insn_token_board.sv
module insn_token_board
    import tkb_pkg::*;
#(
    parameter  int NUM_TOK = 16,
    localparam int TOK_W   = (NUM_TOK > 1) ? $clog2(NUM_TOK) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [OP_W-1:0]  req_op,
    input  logic [TOK_W-1:0] req_tok,
    output logic             resp_valid,
    output logic             resp_ok,
    output logic             resp_full,
    output logic [TOK_W-1:0] resp_tok
);
    logic               fire;
    logic               wr_en, dec_wr, in_range, any_free;
    logic [TOK_W-1:0]   wr_tok, pick, out_tok;
    phase_e             wr_phase, cur;
    status_t            status;
    logic [NUM_TOK-1:0] busy;

    assign req_ready = ~rst;
    assign fire      = req_valid & req_ready;
    assign wr_en     = fire & dec_wr;

    tkb_phase_table #(.NUM_TOK(NUM_TOK), .TOK_W(TOK_W)) u_table (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_tok(wr_tok), .wr_phase(wr_phase),
        .rd_tok(req_tok), .rd_phase(cur), .rd_in_range(in_range),
        .busy(busy)
    );

    tkb_free_pick #(.NUM_TOK(NUM_TOK), .TOK_W(TOK_W)) u_pick (
        .busy(busy), .any_free(any_free), .pick(pick)
    );

    tkb_step_decide #(.TOK_W(TOK_W)) u_decide (
        .op_raw(req_op), .tok(req_tok), .cur(cur), .in_range(in_range),
        .any_free(any_free), .pick(pick),
        .wr_en(dec_wr), .wr_tok(wr_tok), .wr_phase(wr_phase),
        .status(status), .out_tok(out_tok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_ok    <= 1'b0;
            resp_full  <= 1'b0;
            resp_tok   <= '0;
        end else begin
            resp_valid <= fire;
            if (fire) begin
                resp_ok   <= status.ok;
                resp_full <= status.full;
                resp_tok  <= out_tok;
            end
        end
    end

    // R2: one response exactly one cycle after each accepted request
    a_r2_resp_after_req: assert property (@(posedge clk) disable iff (rst)
        fire |=> resp_valid);
    a_r2_no_spurious_resp: assert property (@(posedge clk) disable iff (rst)
        !fire |=> !resp_valid);
    // R4: a full refusal is never also an ok
    a_r4_full_not_ok: assert property (@(posedge clk) disable iff (rst)
        resp_full |-> !resp_ok);
    // R3: the chosen slot is free, and a granted allocate adds one busy slot
    a_r3_pick_free: assert property (@(posedge clk) disable iff (rst)
        any_free |-> !busy[pick]);
    a_r3_alloc_grows: assert property (@(posedge clk) disable iff (rst)
        (fire && req_op == OP_ALLOC && any_free) |=>
            ($countones(busy) == $past($countones(busy)) + 1));
    // R10: a rejected request leaves the occupancy untouched
    a_r10_reject_stable: assert property (@(posedge clk) disable iff (rst)
        (fire && !status.ok) |=> $stable(busy));
endmodule

// File: tb/sim_insn_token_board.sv
module sim_insn_token_board;
    localparam int N  = 16;
    localparam int TW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [3:0]    req_op = '0;
    logic [TW-1:0] req_tok = '0;
    logic          resp_valid, resp_ok, resp_full;
    logic [TW-1:0] resp_tok;

    always #10 clk = ~clk;   // 50 MHz

    insn_token_board #(.NUM_TOK(N)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_tok(req_tok), .resp_valid(resp_valid),
        .resp_ok(resp_ok), .resp_full(resp_full), .resp_tok(resp_tok)
    );

    // Reference state: 0 free, 1 allocated, 2 fetched, 3 decoded,
    // 4 executed, 5 loaded, 6 stored, 7 committed awaiting global store.
    int    ph [N];
    int    vectors = 0, miscompares = 0;
    bit    e_ok, e_full;
    int    e_tok;
    string e_tag, tag_ovr = "";
    logic [31:0] rs = 32'h1234_5678;

    function automatic logic [31:0] rnd();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
        return rs;
    endfunction

    task automatic model(input int op, input int tok);
        int cur, found;
        cur = ph[tok];
        e_ok = 0; e_full = 0; e_tok = tok;
        case (op)
            0: begin
                found = -1;
                for (int i = 0; i < N; i++) if (found < 0 && ph[i] == 0) found = i;
                if (found >= 0) begin
                    e_tag = "R3"; e_ok = 1; e_tok = found; ph[found] = 1;
                end else begin
                    e_tag = "R4"; e_full = 1; e_tok = 0;
                end
            end
            1, 2, 3: begin
                e_tag = "R5";
                if (cur == op) begin e_ok = 1; ph[tok] = op + 1; end
            end
            4: begin e_tag = "R6"; if (cur == 4) begin e_ok = 1; ph[tok] = 5; end end
            5: begin e_tag = "R6"; if (cur == 4 || cur == 5) begin e_ok = 1; ph[tok] = 6; end end
            6: begin
                e_tag = "R7";
                if (cur == 4 || cur == 5) begin e_ok = 1; ph[tok] = 0; end
                else if (cur == 6)        begin e_ok = 1; ph[tok] = 7; end
            end
            7: begin e_tag = "R8"; if (cur >= 1 && cur <= 6) begin e_ok = 1; ph[tok] = 0; end end
            8: begin e_tag = "R9"; if (cur == 7) begin e_ok = 1; ph[tok] = 0; end end
            default: e_tag = "R10";
        endcase
        if (op != 0 && cur == 0) e_tag = "R10";
        if (tag_ovr != "") e_tag = tag_ovr;
    endtask

    task automatic check(input bit ev, input string tag);
        vectors++;
        if (resp_valid !== ev ||
            (ev && (resp_ok !== e_ok || resp_full !== e_full || resp_tok !== TW'(e_tok)))) begin
            miscompares++;
            $display("FAIL %s: got v=%0b ok=%0b full=%0b tok=%0d, expected v=%0b ok=%0b full=%0b tok=%0d",
                     tag, resp_valid, resp_ok, resp_full, resp_tok, ev, e_ok, e_full, e_tok);
        end
    endtask

    // Called at a falling edge; the response is checked at the next one.
    task automatic issue(input int op, input int tok);
        req_valid = 1'b1; req_op = 4'(op); req_tok = TW'(tok);
        model(op, tok);
        @(negedge clk);
        check(1'b1, e_tag);
    endtask

    task automatic idle();
        req_valid = 1'b0;
        @(negedge clk);
        check(1'b0, "R2");
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    function automatic int next_op(input int cur);
        int r;
        r = int'(rnd() % 4);
        case (cur)
            0: return 0;
            1, 2, 3: return cur;
            4: return 4 + r;
            5: return (r < 2) ? 5 + r : 7;
            6: return (r < 2) ? 6 : 7;
            default: return 8;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: got hung run, expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < N; i++) ph[i] = 0;
        repeat (3) @(negedge clk);
        // R1: reset holds the interface quiet
        vectors++;
        if (req_ready !== 1'b0 || resp_valid !== 1'b0) begin
            miscompares++;
            $display("FAIL R1: got ready=%0b v=%0b, expected 0 0", req_ready, resp_valid);
        end
        rst = 1'b0;
        @(negedge clk);
        vectors++;
        if (req_ready !== 1'b1 || resp_valid !== 1'b0) begin
            miscompares++;
            $display("FAIL R1: got ready=%0b v=%0b, expected 1 0", req_ready, resp_valid);
        end

        // R3 / R4: fill the pool, then overflow it
        for (int i = 0; i < N; i++) issue(0, 0);
        issue(0, 0);
        issue(0, 0);
        // R11: free middle tokens out of order, check reuse order
        issue(1, 9); issue(2, 9); issue(3, 9);
        issue(1, 4); issue(2, 4); issue(3, 4); issue(4, 4);
        tag_ovr = "R11";
        issue(6, 9);      // younger one retires first
        issue(7, 12);
        issue(6, 4);
        issue(0, 0);      // lowest free is 4
        issue(0, 0);      // then 9
        issue(0, 0);      // then 12
        tag_ovr = "";
        idle();

        // R5 / R10: out-of-order steps are refused and change nothing
        issue(3, 2);
        issue(2, 2);
        issue(1, 2);
        issue(1, 2);
        issue(11, 2);
        issue(15, 3);
        // R6 / R9: store path with commit, then delayed global store
        issue(2, 2); issue(3, 2);
        issue(5, 2);
        issue(4, 2);      // read after store refused
        issue(5, 2);      // second store refused
        issue(8, 2);      // global store before commit refused
        issue(6, 2);
        issue(7, 2);      // abort after commit refused
        issue(6, 2);      // second commit refused
        issue(8, 2);
        issue(8, 2);      // token already free
        idle();

        // Empty the pool through the normal interface
        for (int t = 0; t < N; t++) begin
            if (ph[t] == 7) issue(8, t);
            else if (ph[t] != 0) issue(7, t);
        end
        issue(7, 5);      // R10: abort of a free token
        idle();

        // Mixed random traffic, mostly legal next steps (R2..R11)
        for (int k = 0; k < 4000; k++) begin
            int t, op, r;
            t = int'(rnd() % N);
            r = int'(rnd() % 16);
            if (r < 2)       op = 0;
            else if (r < 14) op = next_op(ph[t]);
            else             op = int'(rnd() % 16);
            if (r == 15) idle();
            issue(op, t);
        end
        idle();
        idle();
        finish_run();
    end
endmodule